// File: doc/BRIEF.md
# Tributary Demultiplexer and Justification Remover

This block takes an aggregate serial stream in which four lower-rate tributaries are interleaved bit by bit. It hands each bit to the tributary it belongs to and strips the framing, service and justification-control bits. It also decides, once per frame and per tributary, whether the single justification opportunity bit carries data or a stuffing pulse. The frame is 848 bits long. Each tributary owns 212 bits of it, as four sets of 53 bits.

An upstream frame aligner supplies the aggregate bit, a bit enable, the 0-based bit position within the frame and a sync flag. The block acts only on enabled bits while sync is held. For every accepted payload bit it raises a one-cycle valid strobe on the matching tributary output, one clock after the bit is presented. A later smoothing stage, which is outside this block, turns the bursty strobes into an even clock.

Each tributary's three control bits are held in a small register until that tributary's opportunity bit arrives. A 2-of-3 vote over them decides whether the opportunity bit is stuffing, so a single corrupted control bit does not change the outcome.

Top module: `trib_demux_destuff`

## Requirements
- R1: While reset is active, and in the first cycle after it, every bit of `trib_valid` is 0.
- R2: An accepted bit at 0-based frame position p belongs to tributary p mod 4. When it is payload, `trib_valid[p mod 4]` is 1 in the next cycle and `trib_data[p mod 4]` equals the bit.
- R3: Tributary bit index k = p div 4 (0-based, 0..211) in the range 0..2 is framing/service overhead and never produces a valid strobe.
- R4: Tributary bits k = 53, 106 and 159 are justification control bits c0, c1 and c2. They are never valid, and each is stored for its own tributary.
- R5: Every tributary bit other than those of R3, R4 and R6 produces a valid strobe, so a tributary yields 205 bits per frame when its opportunity bit is stuffing and 206 when it is not.
- R6: Tributary bit k = 160 (aggregate positions 640 to 643) is the opportunity bit. It is dropped when at least two of c0, c1, c2 are 1 and kept otherwise: code 000 keeps it, code 111 drops it.
- R7: While `sync_ok` is 0, no valid strobe is produced, and all stored control bits are cleared to 000.
- R8: A cycle with `bit_en` at 0 produces no valid strobe and changes no stored control bit.
- R9: A `frame_pos` of 848 or more is ignored: no strobe, and no control bit is stored.
- R10: At most one bit of `trib_valid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Aggregate data bit |
| bit_en | input | 1 | Qualifies `bit_in` and `frame_pos` for this cycle |
| frame_pos | input | 10 | 0-based bit position within the 848-bit frame |
| sync_ok | input | 1 | Frame aligner reports sync |
| trib_data | output | 4 | Payload bit per tributary, meaningful with its valid |
| trib_valid | output | 4 | One-cycle payload strobe per tributary |

## Verification
The assertions watch the block's gating on every cycle. They check that no strobe follows a cycle without sync, without enable or with an out-of-range position. They also check that at most one tributary strobes at a time, that a strobed bit equals the input of the previous cycle on the right lane, and that losing sync empties the control store. Which positions count as overhead and how the vote resolves each of the eight control codes can only be shown by the bench. Its sweeps run whole frames with every code on every tributary, with enable gaps, with a sync drop between the control bits and the opportunity bit, and with out-of-range positions.

// File: rtl/dmx_pkg.sv
// Shared types for the tributary demultiplexer.
// Assumes nothing beyond standard SystemVerilog enum support.
package dmx_pkg;

    // Role a frame position plays for its tributary
    typedef enum logic [1:0] {
        SLOT_DROP = 2'd0,   // overhead or out of frame: discarded
        SLOT_CTRL = 2'd1,   // justification control bit
        SLOT_OPP  = 2'd2,   // justification opportunity bit
        SLOT_DATA = 2'd3    // plain payload
    } slot_kind_e;

endpackage

// File: rtl/dmx_pos_decode.sv
// Position decoder: maps a 0-based aggregate frame position to the tributary
// that owns it, the role of that bit, and (for control bits) which control
// bit it is. Purely combinational.
// Assumes bit-by-bit interleave and sets of SET_LEN bits per tributary.
module dmx_pos_decode
    import dmx_pkg::*;
#(
    parameter int NUM_TRIB = 4,
    parameter int SET_LEN  = 53,
    parameter int NUM_SETS = 4,
    parameter int OH_BITS  = 3,
    parameter int OPP_OFS  = 1,
    parameter int POS_W    = 10,
    parameter int TRIB_W   = 2,
    parameter int CSEL_W   = 2
) (
    input  logic [POS_W-1:0]  frame_pos,
    output logic [TRIB_W-1:0] trib_idx,
    output slot_kind_e        kind,
    output logic [CSEL_W-1:0] ctrl_sel,
    output logic              in_frame
);
    localparam int TRIB_LEN  = SET_LEN * NUM_SETS;
    localparam int FRAME_LEN = TRIB_LEN * NUM_TRIB;

    int pos_i;
    int tbit_i;
    int set_i;
    int ofs_i;

    // Split the position into tributary, set and offset, then classify it
    always_comb begin
        pos_i    = int'(frame_pos);
        tbit_i   = pos_i / NUM_TRIB;
        set_i    = tbit_i / SET_LEN;
        ofs_i    = tbit_i % SET_LEN;
        trib_idx = TRIB_W'(pos_i % NUM_TRIB);
        ctrl_sel = '0;
        in_frame = (pos_i < FRAME_LEN);
        kind     = SLOT_DATA;
        if (!in_frame) begin
            kind = SLOT_DROP;
        end else if (set_i == 0 && ofs_i < OH_BITS) begin
            kind = SLOT_DROP;
        end else if (set_i != 0 && ofs_i == 0) begin
            kind     = SLOT_CTRL;
            ctrl_sel = CSEL_W'(set_i - 1);
        end else if (set_i == NUM_SETS - 1 && ofs_i == OPP_OFS) begin
            kind = SLOT_OPP;
        end
    end

endmodule

// File: rtl/dmx_just_store.sv
// Justification store for one tributary: holds that tributary's control bits
// for the current frame and reports by majority vote whether the opportunity
// bit should be kept (minority of ones) or dropped (majority of ones).
// Assumes all control bits of a frame arrive before its opportunity bit.
module dmx_just_store #(
    parameter int NUM_CTRL = 3,
    parameter int CSEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_ok,
    input  logic              cap_en,
    input  logic [CSEL_W-1:0] cap_sel,
    input  logic              cap_bit,
    output logic              keep_opp
);
    logic [NUM_CTRL-1:0] code_q;
    int                  ones;

    // Capture control bits; forget them whenever sync is lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (!sync_ok) begin
            code_q <= '0;
        end else if (cap_en && int'(cap_sel) < NUM_CTRL) begin
            code_q[cap_sel] <= cap_bit;
        end
    end

    // Majority vote over the stored control bits
    always_comb begin
        ones = 0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            ones = ones + int'(code_q[i]);
        end
        keep_opp = (2 * ones < NUM_CTRL);
    end

    // R7
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |=> keep_opp);

endmodule

// File: rtl/dmx_trib_out.sv
// Output stage: registers one payload bit per accepted cycle onto the lane of
// its tributary and raises that lane's valid for exactly one cycle.
// Assumes the decoder classification and the keep decision are settled in
// the same cycle as the bit.
module dmx_trib_out
    import dmx_pkg::*;
#(
    parameter int NUM_TRIB = 4,
    parameter int TRIB_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [TRIB_W-1:0]   trib_idx,
    input  slot_kind_e          kind,
    input  logic [NUM_TRIB-1:0] keep_opp,
    input  logic                bit_in,
    output logic [NUM_TRIB-1:0] trib_data,
    output logic [NUM_TRIB-1:0] trib_valid
);
    logic hit;

    // Decide whether this cycle's bit is a payload bit to forward
    always_comb begin
        hit = accept && ((kind == SLOT_DATA) ||
                         (kind == SLOT_OPP && keep_opp[trib_idx]));
    end

    // Strobe the owning lane and latch its data bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trib_valid <= '0;
            trib_data  <= '0;
        end else begin
            trib_valid <= '0;
            if (hit) begin
                trib_valid[trib_idx] <= 1'b1;
                trib_data[trib_idx]  <= bit_in;
            end
        end
    end

    for (genvar t = 0; t < NUM_TRIB; t++) begin : g_lane_chk
        // R2
        lane_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trib_valid[t] |-> (trib_data[t] == $past(bit_in)) &&
                              ($past(trib_idx) == TRIB_W'(t)));
    end

endmodule

// File: rtl/trib_demux_destuff.sv
// Tributary demultiplexer and justification remover. Splits a bit-interleaved
// aggregate into NUM_TRIB lanes, discards overhead and control bits, and keeps
// or drops each lane's opportunity bit according to its voted control code.
// Assumes frame_pos comes from an external aligner and is meaningful only
// while sync_ok is high; bits are consumed only when bit_en is high.
module trib_demux_destuff
    import dmx_pkg::*;
#(
    parameter  int NUM_TRIB  = 4,
    parameter  int SET_LEN   = 53,
    parameter  int NUM_SETS  = 4,
    parameter  int OH_BITS   = 3,
    parameter  int OPP_OFS   = 1,
    localparam int FRAME_LEN = NUM_TRIB * SET_LEN * NUM_SETS,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int TRIB_W    = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1,
    localparam int NUM_CTRL  = NUM_SETS - 1,
    localparam int CSEL_W    = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                bit_en,
    input  logic [POS_W-1:0]    frame_pos,
    input  logic                sync_ok,
    output logic [NUM_TRIB-1:0] trib_data,
    output logic [NUM_TRIB-1:0] trib_valid
);
    logic [TRIB_W-1:0]   trib_idx;
    slot_kind_e          kind;
    logic [CSEL_W-1:0]   ctrl_sel;
    logic                in_frame;
    logic                accept;
    logic [NUM_TRIB-1:0] keep_opp;

    dmx_pos_decode #(
        .NUM_TRIB (NUM_TRIB),
        .SET_LEN  (SET_LEN),
        .NUM_SETS (NUM_SETS),
        .OH_BITS  (OH_BITS),
        .OPP_OFS  (OPP_OFS),
        .POS_W    (POS_W),
        .TRIB_W   (TRIB_W),
        .CSEL_W   (CSEL_W)
    ) u_decode (
        .frame_pos (frame_pos),
        .trib_idx  (trib_idx),
        .kind      (kind),
        .ctrl_sel  (ctrl_sel),
        .in_frame  (in_frame)
    );

    // A bit is consumed only when enabled, in sync and inside the frame
    always_comb begin
        accept = bit_en && sync_ok && in_frame;
    end

    for (genvar t = 0; t < NUM_TRIB; t++) begin : g_store
        logic cap_en;

        // Route control-bit captures to this lane's store
        always_comb begin
            cap_en = accept && (kind == SLOT_CTRL) && (trib_idx == TRIB_W'(t));
        end

        dmx_just_store #(
            .NUM_CTRL (NUM_CTRL),
            .CSEL_W   (CSEL_W)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_ok  (sync_ok),
            .cap_en   (cap_en),
            .cap_sel  (ctrl_sel),
            .cap_bit  (bit_in),
            .keep_opp (keep_opp[t])
        );
    end

    dmx_trib_out #(
        .NUM_TRIB (NUM_TRIB),
        .TRIB_W   (TRIB_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .trib_idx   (trib_idx),
        .kind       (kind),
        .keep_opp   (keep_opp),
        .bit_in     (bit_in),
        .trib_data  (trib_data),
        .trib_valid (trib_valid)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (trib_valid == '0));

    // R7
    no_sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |=> (trib_valid == '0));

    // R8
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (trib_valid == '0));

    // R9
    out_of_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(frame_pos) >= FRAME_LEN) |=> (trib_valid == '0));

    // R10
    single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trib_valid));

endmodule

// File: tb/tb_trib_demux_destuff.sv
// Sweeps whole frames over every control code on every lane, with enable
// gaps, a sync drop and out-of-range positions; expectations are derived
// arithmetically from the frame layout.
module tb_trib_demux_destuff;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_en = 1'b0;
    logic [9:0] frame_pos = '0;
    logic       sync_ok = 1'b0;
    logic [3:0] trib_data;
    logic [3:0] trib_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [2:0] code_m [4];
    int obs_cnt [4];

    trib_demux_destuff dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
        .frame_pos(frame_pos), .sync_ok(sync_ok),
        .trib_data(trib_data), .trib_valid(trib_valid)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One cycle: drive inputs, model expectation, check the registered result
    task automatic step(input logic b, input logic en, input int pos, input logic sy);
        logic [3:0] exp_v;
        string tag;
        int t, k, s, o;
        @(negedge clk);
        bit_in = b; bit_en = en; frame_pos = pos[9:0]; sync_ok = sy;
        exp_v = '0;
        t = pos % 4; k = pos / 4; s = k / 53; o = k % 53;
        if (!sy) begin
            tag = "R7";
            for (int i = 0; i < 4; i++) code_m[i] = 3'b000;
        end else if (!en) begin
            tag = "R8";
        end else if (pos >= 848) begin
            tag = "R9";
        end else if (s == 0 && o < 3) begin
            tag = "R3";
        end else if (o == 0) begin
            tag = "R4";
            code_m[t][s-1] = b;
        end else if (s == 3 && o == 1) begin
            tag = "R6";
            if ($countones(code_m[t]) < 2) exp_v[t] = 1'b1;
        end else begin
            tag = "R5";
            exp_v[t] = 1'b1;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (trib_valid[i] !== exp_v[i]) begin
                failures++;
                $display("FAIL %s pos=%0d lane=%0d valid actual=%b expected=%b",
                         tag, pos, i, trib_valid[i], exp_v[i]);
            end else if (exp_v[i] && trib_data[i] !== b) begin
                failures++;
                $display("FAIL R2 pos=%0d lane=%0d data actual=%b expected=%b",
                         pos, i, trib_data[i], b);
            end
            if (trib_valid[i] === 1'b1) obs_cnt[i]++;
        end
        checks++;
        if ($countones(trib_valid) > 1) begin
            failures++;
            $display("FAIL R10 pos=%0d valid actual=%b expected at most one bit",
                     pos, trib_valid);
        end
    endtask

    // Bit content of position p in frame fr, lane codes from fr unless forced
    function automatic logic frame_bit(input int fr, input int p, input int force_code);
        int t, k, s, o, code;
        t = p % 4; k = p / 4; s = k / 53; o = k % 53;
        code = (force_code >= 0) ? force_code : (fr * 4 + t) % 8;
        if (s != 0 && o == 0) return logic'((code >> (s - 1)) & 1);
        return logic'(((p * 5 + fr * 11) % 7) < 3);
    endfunction

    // One full frame; optional enable gaps and a one-cycle sync drop
    task automatic run_frame(input int fr, input bit gap, input int drop_at,
                             input int force_code);
        int code, exp_n;
        for (int i = 0; i < 4; i++) obs_cnt[i] = 0;
        for (int p = 0; p < 848; p++) begin
            logic b;
            b = frame_bit(fr, p, force_code);
            if (p == drop_at) step(~b, 1'b1, p, 1'b0);
            if (gap) step(~b, 1'b0, p, 1'b1);
            step(b, 1'b1, p, 1'b1);
        end
        if (drop_at < 0) begin
            for (int t = 0; t < 4; t++) begin
                code = (force_code >= 0) ? force_code : (fr * 4 + t) % 8;
                exp_n = ($countones(code[2:0]) >= 2) ? 205 : 206;
                checks++;
                if (obs_cnt[t] != exp_n) begin
                    failures++;
                    $display("FAIL R5/R6 frame=%0d lane=%0d count actual=%0d expected=%0d",
                             fr, t, obs_cnt[t], exp_n);
                end
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) code_m[i] = 3'b000;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (trib_valid !== 4'b0000) begin
            failures++;
            $display("FAIL R1 valid in reset actual=%b expected=0000", trib_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        checks++;
        if (trib_valid !== 4'b0000) begin
            failures++;
            $display("FAIL R1 valid after reset actual=%b expected=0000", trib_valid);
        end
        // R2 R3 R4 R5 R6: every control code on every lane, full rate
        for (int fr = 0; fr < 8; fr++) run_frame(fr, 1'b0, -1, -1);
        // R8: enable gaps between every bit
        run_frame(3, 1'b1, -1, -1);
        // R6: all lanes stuffed, then all lanes forced to keep
        run_frame(9, 1'b0, -1, 7);
        run_frame(10, 1'b0, -1, 0);
        // R7: sync lost between control bits and opportunity bits clears the code
        run_frame(11, 1'b0, 640, 7);
        // R9: positions beyond the frame
        for (int p = 848; p < 1024; p++) step(1'b1, 1'b1, p, 1'b1);
        // R7: a stretch without sync
        for (int p = 0; p < 200; p++) step(logic'(p % 2), 1'b1, p + 13, 1'b0);
        run_frame(12, 1'b0, -1, -1);
        finish_run();
    end

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule